// File: doc/BRIEF.md
# Two-Region Threshold Eviction Manager

This block orders up to sixteen cache block slots of a flash write buffer. Each cached slot sits in one of two recency lists: a work list that holds recently written blocks and an eviction list that holds blocks already judged cheap to write back. Write accesses update the order. An eviction request returns the slot to flush. While the write path is quiet, a background scan asks an external cost unit for the cost of each work-list block over a request/response handshake. Blocks whose cost does not exceed a threshold move to the eviction list.

The cost arithmetic and all data movement sit outside the block. The requester supplies the slot, whether the block was already cached, the page count after the write, and the block's current cost. The block reports the victim slot, the threshold in use, and which slots are cached and which of them sit in the eviction list. In dynamic mode the threshold adapts to how productive each scan was.

Top module: `evict_region_mgr`

## Requirements
- R1: After reset no slot is cached, the eviction list is empty, costReq is low and the threshold equals one step. One step is 1e-6 in a fixed-point cost with COST_FRAC fractional bits, rounded to the nearest integer (4295 for 32 fractional bits).
- R2: On evictReq the least-recent block of the eviction list is chosen. In the cycle after the request, victimValid is high for one cycle with victimSlot, and that slot is no longer cached. With no block cached, victimValid stays low.
- R3: If the eviction list is empty, an eviction takes the least-recent block of the work list.
- R4: A write to a new block (accHit low), or a write to a block already in the work list, places that slot at the most-recent end of the work list.
- R5: A write hit on a block in the eviction list compares accCost with the threshold. If accCost is strictly greater, the slot goes to the most-recent end of the work list. Otherwise it goes to the most-recent end of the eviction list.
- R6: A write whose page count after the access equals PAGE_LIMIT (64) puts the slot at the least-recent end of the eviction list. This rule takes precedence over R4 and R5.
- R7: In the cycle after a write, a scan starts only if the eviction list holds at most NMIN blocks (default 1). Otherwise no cost request is raised.
- R8: The scan visits work-list blocks from least-recent toward most-recent. For each block it holds costReq high with costSlot steady until costValid. A returned costValue at or below the threshold moves that slot to the most-recent end of the eviction list.
- R9: A scan ends once TSCAN blocks have moved. TSCAN is 5% of the slot count rounded up, and at least 1. Cheaper blocks later in the walk stay in the work list.
- R10: A write or an eviction request preempts a running scan. A cost response that arrives in the same cycle is discarded. A later scan starts afresh from the least-recent work-list block.
- R11: With dynMode high, a scan that moves TSCAN blocks lowers the threshold by one step, and a complete walk that moves none raises it by one step. The threshold stays between one step and the all-ones value. With dynMode low the threshold never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| accValid | input | 1 | Write access completed this cycle (never together with evictReq) |
| accSlot | input | SLOT_W | Slot written |
| accHit | input | 1 | Block was already cached in the slot |
| accPages | input | PAGE_W | Cached page count of the block after the write |
| accCost | input | COST_W | Block cost after the write |
| evictReq | input | 1 | Request for a victim slot |
| dynMode | input | 1 | Adaptive threshold enable |
| costReq | output | 1 | Cost query pending |
| costSlot | output | SLOT_W | Slot whose cost is queried |
| costValid | input | 1 | Cost response strobe |
| costValue | input | COST_W | Returned cost |
| victimValid | output | 1 | Victim reported |
| victimSlot | output | SLOT_W | Evicted slot |
| threshold | output | COST_W | Current cost threshold |
| slotValid | output | NUM_SLOTS | Per-slot cached flag |
| slotInEvict | output | NUM_SLOTS | Per-slot eviction-list membership |

## Verification
A write can land in the same cycle as the cost response that would move a work-list block into the eviction list. The bench stops the automatic cost responder and lets a scan wait on a cheap block. It then drives costValid with a zero cost and a write to another slot on the same edge. The check expects the eviction list to stay empty, and expects the restarted scan to ask again for the same least-recent slot before the move is finally accepted.

// File: rtl/evict_mgr_pkg.sv
`timescale 1ns/1ps
package evict_mgr_pkg;
  localparam int SLOT_IDX_W = 8;

  typedef enum logic [1:0] {
    CMD_IDLE,
    CMD_TO_MRU,
    CMD_TO_LRU,
    CMD_FREE
  } slotOp_e;

  typedef struct packed {
    slotOp_e                 op;
    logic                    toEvict;
    logic [SLOT_IDX_W-1:0]   slot;
  } slotCmd_t;

  typedef enum logic {
    SCAN_OFF,
    SCAN_ON
  } scanState_e;
endpackage

// File: rtl/evict_slot_table.sv
`timescale 1ns/1ps
module evict_slot_table
  import evict_mgr_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 4,
  parameter int CNT_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  slotCmd_t             cmd,
  input  logic [SLOT_W-1:0]    qAge,
  output logic [NUM_SLOTS-1:0] validMask,
  output logic [NUM_SLOTS-1:0] evictMask,
  output logic [CNT_W-1:0]     workCnt,
  output logic [CNT_W-1:0]     evictCnt,
  output logic [SLOT_W-1:0]    workLru,
  output logic [SLOT_W-1:0]    evictLru,
  output logic [SLOT_W-1:0]    qSlot,
  output logic                 qHit
);
  logic [NUM_SLOTS-1:0] validQ, regionQ, validD, regionD;
  logic [SLOT_W-1:0]    ageQ [NUM_SLOTS];
  logic [SLOT_W-1:0]    ageD [NUM_SLOTS];
  logic [SLOT_W-1:0]    cmdSlot;
  logic                 oldV, oldR;
  logic [SLOT_W-1:0]    oldA;
  logic [CNT_W-1:0]     lruPos;

  // occupancy and list tails
  always_comb begin
    workCnt  = '0;
    evictCnt = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (validQ[i]) begin
        if (regionQ[i]) evictCnt = evictCnt + CNT_W'(1);
        else            workCnt  = workCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    workLru  = '0;
    evictLru = '0;
    qSlot    = '0;
    qHit     = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (validQ[i] && !regionQ[i] && CNT_W'(ageQ[i]) == workCnt - CNT_W'(1))
        workLru = SLOT_W'(i);
      if (validQ[i] && regionQ[i] && CNT_W'(ageQ[i]) == evictCnt - CNT_W'(1))
        evictLru = SLOT_W'(i);
      if (validQ[i] && !regionQ[i] && ageQ[i] == qAge) begin
        qSlot = SLOT_W'(i);
        qHit  = 1'b1;
      end
    end
  end

  // next state for one placement command
  always_comb begin
    cmdSlot = cmd.slot[SLOT_W-1:0];
    oldV    = validQ[cmdSlot];
    oldR    = regionQ[cmdSlot];
    oldA    = ageQ[cmdSlot];
    lruPos  = (cmd.toEvict ? evictCnt : workCnt)
            - ((oldV && oldR == cmd.toEvict) ? CNT_W'(1) : CNT_W'(0));
    validD  = validQ;
    regionD = regionQ;
    ageD    = ageQ;
    if (cmd.op != CMD_IDLE) begin
      for (int j = 0; j < NUM_SLOTS; j++) begin
        if (SLOT_W'(j) != cmdSlot && validQ[j]) begin
          if (oldV && regionQ[j] == oldR && ageQ[j] > oldA)
            ageD[j] = ageD[j] - SLOT_W'(1);
          if (cmd.op == CMD_TO_MRU && regionQ[j] == cmd.toEvict)
            ageD[j] = ageD[j] + SLOT_W'(1);
        end
      end
    end
    case (cmd.op)
      CMD_TO_MRU: begin
        validD[cmdSlot]  = 1'b1;
        regionD[cmdSlot] = cmd.toEvict;
        ageD[cmdSlot]    = '0;
      end
      CMD_TO_LRU: begin
        validD[cmdSlot]  = 1'b1;
        regionD[cmdSlot] = cmd.toEvict;
        ageD[cmdSlot]    = SLOT_W'(lruPos);
      end
      CMD_FREE: begin
        validD[cmdSlot]  = 1'b0;
        regionD[cmdSlot] = 1'b0;
        ageD[cmdSlot]    = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ  <= '0;
      regionQ <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) ageQ[i] <= '0;
    end else begin
      validQ  <= validD;
      regionQ <= regionD;
      ageQ    <= ageD;
    end
  end

  assign validMask = validQ;
  assign evictMask = regionQ;

  // R2
  region_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (evictMask & ~validMask) == '0);

  // R2
  free_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.op == CMD_FREE) |-> validQ[cmd.slot[SLOT_W-1:0]]);
endmodule

// File: rtl/evict_scan_ctrl.sv
`timescale 1ns/1ps
module evict_scan_ctrl
  import evict_mgr_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int SLOT_W     = 4,
  parameter int CNT_W      = 5,
  parameter int PAGE_W     = 7,
  parameter int PAGE_LIMIT = 64,
  parameter int COST_W     = 32,
  parameter int COST_FRAC  = 32,
  parameter int NMIN       = 1,
  parameter int TSCAN      = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accValid,
  input  logic [SLOT_W-1:0]    accSlot,
  input  logic                 accHit,
  input  logic [PAGE_W-1:0]    accPages,
  input  logic [COST_W-1:0]    accCost,
  input  logic                 evictReq,
  input  logic                 dynMode,
  output logic                 costReq,
  output logic [SLOT_W-1:0]    costSlot,
  input  logic                 costValid,
  input  logic [COST_W-1:0]    costValue,
  output logic                 victimValid,
  output logic [SLOT_W-1:0]    victimSlot,
  output logic [COST_W-1:0]    threshold,
  output slotCmd_t             cmd,
  output logic [SLOT_W-1:0]    qAge,
  input  logic [NUM_SLOTS-1:0] validMask,
  input  logic [NUM_SLOTS-1:0] evictMask,
  input  logic [CNT_W-1:0]     workCnt,
  input  logic [CNT_W-1:0]     evictCnt,
  input  logic [SLOT_W-1:0]    workLru,
  input  logic [SLOT_W-1:0]    evictLru,
  input  logic [SLOT_W-1:0]    qSlot,
  input  logic                 qHit
);
  localparam logic [COST_W-1:0] STEP =
    COST_W'(((64'd1 << COST_FRAC) + 64'd500000) / 64'd1000000);
  localparam logic [COST_W-1:0] THR_MAX = '1;

  scanState_e         scanQ, scanD;
  logic [CNT_W-1:0]   skipQ, skipD, movedQ, movedD;
  logic [COST_W-1:0]  thrQ, thrD;
  logic               trigQ, vicValidQ;
  logic [SLOT_W-1:0]  vicSlotQ, victimPick;
  logic               targetOk, finish, fullScan, anyCached;

  always_comb begin
    cmd        = '{op: CMD_IDLE, toEvict: 1'b0, slot: '0};
    scanD      = scanQ;
    skipD      = skipQ;
    movedD     = movedQ;
    thrD       = thrQ;
    finish     = 1'b0;
    fullScan   = 1'b0;
    anyCached  = (evictCnt != '0) || (workCnt != '0);
    victimPick = (evictCnt != '0) ? evictLru : workLru;
    qAge       = SLOT_W'(workCnt - skipQ - CNT_W'(1));
    targetOk   = (skipQ < workCnt) && qHit;
    costReq    = (scanQ == SCAN_ON) && targetOk;
    costSlot   = qSlot;

    if (accValid) begin
      scanD    = SCAN_OFF;
      cmd.slot = SLOT_IDX_W'(accSlot);
      cmd.op   = CMD_TO_MRU;
      if (accPages == PAGE_W'(PAGE_LIMIT)) begin
        cmd.op      = CMD_TO_LRU;
        cmd.toEvict = 1'b1;
      end else if (accHit && validMask[accSlot] && evictMask[accSlot]) begin
        cmd.toEvict = (accCost <= thrQ);
      end
    end else if (evictReq) begin
      scanD = SCAN_OFF;
      if (anyCached) begin
        cmd.op   = CMD_FREE;
        cmd.slot = SLOT_IDX_W'(victimPick);
      end
    end else if (scanQ == SCAN_OFF) begin
      if (trigQ && evictCnt <= CNT_W'(NMIN)) begin
        scanD  = SCAN_ON;
        skipD  = '0;
        movedD = '0;
      end
    end else if (!targetOk) begin
      finish = 1'b1;
    end else if (costValid) begin
      if (costValue <= thrQ) begin
        cmd.op      = CMD_TO_MRU;
        cmd.toEvict = 1'b1;
        cmd.slot    = SLOT_IDX_W'(qSlot);
        movedD      = movedQ + CNT_W'(1);
        if (movedQ + CNT_W'(1) >= CNT_W'(TSCAN)) begin
          finish   = 1'b1;
          fullScan = 1'b1;
        end
      end else begin
        skipD = skipQ + CNT_W'(1);
      end
    end

    if (finish) begin
      scanD = SCAN_OFF;
      if (dynMode) begin
        if (fullScan)
          thrD = (thrQ < (STEP << 1)) ? STEP : thrQ - STEP;
        else if (movedQ == '0)
          thrD = (thrQ > THR_MAX - STEP) ? THR_MAX : thrQ + STEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scanQ     <= SCAN_OFF;
      skipQ     <= '0;
      movedQ    <= '0;
      thrQ      <= STEP;
      trigQ     <= 1'b0;
      vicValidQ <= 1'b0;
      vicSlotQ  <= '0;
    end else begin
      scanQ     <= scanD;
      skipQ     <= skipD;
      movedQ    <= movedD;
      thrQ      <= thrD;
      trigQ     <= accValid;
      vicValidQ <= !accValid && evictReq && anyCached;
      vicSlotQ  <= victimPick;
    end
  end

  assign victimValid = vicValidQ;
  assign victimSlot  = vicSlotQ;
  assign threshold   = thrQ;

  // R11
  thr_range_chk: assert property (@(posedge clk) disable iff (rst)
    thrQ >= STEP);

  // R11
  thr_static_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(dynMode) |-> $stable(thrQ));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (costReq && !costValid && !accValid && !evictReq) |=> (costReq && $stable(costSlot)));

  // R2
  victim_freed_chk: assert property (@(posedge clk) disable iff (rst)
    victimValid |-> !validMask[victimSlot]);

  // R9
  scan_limit_chk: assert property (@(posedge clk) disable iff (rst)
    movedQ <= CNT_W'(TSCAN));

  // R6
  pagefull_chk: assert property (@(posedge clk) disable iff (rst)
    (accValid && accPages == PAGE_W'(PAGE_LIMIT)) |=> evictMask[$past(accSlot)]);
endmodule

// File: rtl/evict_region_mgr.sv
`timescale 1ns/1ps
module evict_region_mgr
  import evict_mgr_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int PAGE_LIMIT = 64,
  parameter int COST_W     = 32,
  parameter int COST_FRAC  = 32,
  parameter int NMIN       = 1,
  parameter int TSCAN      = ((NUM_SLOTS * 5 + 99) / 100 < 1) ? 1 : (NUM_SLOTS * 5 + 99) / 100,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W     = $clog2(NUM_SLOTS + 1),
  localparam int PAGE_W    = $clog2(PAGE_LIMIT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accValid,
  input  logic [SLOT_W-1:0]    accSlot,
  input  logic                 accHit,
  input  logic [PAGE_W-1:0]    accPages,
  input  logic [COST_W-1:0]    accCost,
  input  logic                 evictReq,
  input  logic                 dynMode,
  output logic                 costReq,
  output logic [SLOT_W-1:0]    costSlot,
  input  logic                 costValid,
  input  logic [COST_W-1:0]    costValue,
  output logic                 victimValid,
  output logic [SLOT_W-1:0]    victimSlot,
  output logic [COST_W-1:0]    threshold,
  output logic [NUM_SLOTS-1:0] slotValid,
  output logic [NUM_SLOTS-1:0] slotInEvict
);
  slotCmd_t          cmd;
  logic [SLOT_W-1:0] qAge, qSlot, workLru, evictLru;
  logic              qHit;
  logic [CNT_W-1:0]  workCnt, evictCnt;

  evict_scan_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W),
    .PAGE_LIMIT(PAGE_LIMIT), .COST_W(COST_W), .COST_FRAC(COST_FRAC),
    .NMIN(NMIN), .TSCAN(TSCAN)
  ) i_ctrl (
    .clk(clk), .rst(rst),
    .accValid(accValid), .accSlot(accSlot), .accHit(accHit),
    .accPages(accPages), .accCost(accCost),
    .evictReq(evictReq), .dynMode(dynMode),
    .costReq(costReq), .costSlot(costSlot),
    .costValid(costValid), .costValue(costValue),
    .victimValid(victimValid), .victimSlot(victimSlot), .threshold(threshold),
    .cmd(cmd), .qAge(qAge),
    .validMask(slotValid), .evictMask(slotInEvict),
    .workCnt(workCnt), .evictCnt(evictCnt),
    .workLru(workLru), .evictLru(evictLru),
    .qSlot(qSlot), .qHit(qHit)
  );

  evict_slot_table #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) i_table (
    .clk(clk), .rst(rst), .cmd(cmd), .qAge(qAge),
    .validMask(slotValid), .evictMask(slotInEvict),
    .workCnt(workCnt), .evictCnt(evictCnt),
    .workLru(workLru), .evictLru(evictLru),
    .qSlot(qSlot), .qHit(qHit)
  );
endmodule

// File: tb/test_evict_region_mgr.sv
`timescale 1ns/1ps
module test_evict_region_mgr;
  localparam int N = 16;
  localparam logic [31:0] STEP = 32'(((64'd1 << 32) + 64'd500000) / 64'd1000000);
  localparam logic [31:0] CMAX = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst;
  logic        accValid, accHit, evictReq, dynMode;
  logic [3:0]  accSlot;
  logic [6:0]  accPages;
  logic [31:0] accCost;
  logic        costReq, costValid, victimValid;
  logic [3:0]  costSlot, victimSlot;
  logic [31:0] costValue, threshold;
  logic [N-1:0] slotValid, slotInEvict;

  logic        respEn, respValid, manValid;
  logic [31:0] respVal, manVal;
  logic [31:0] costTable [N];
  int          compared = 0;
  int          mismatched = 0;

  assign costValid = respValid | manValid;
  assign costValue = respEn ? respVal : manVal;

  always #2.5 clk = ~clk;

  evict_region_mgr i_evict_region_mgr (
    .clk(clk), .rst(rst),
    .accValid(accValid), .accSlot(accSlot), .accHit(accHit),
    .accPages(accPages), .accCost(accCost),
    .evictReq(evictReq), .dynMode(dynMode),
    .costReq(costReq), .costSlot(costSlot),
    .costValid(costValid), .costValue(costValue),
    .victimValid(victimValid), .victimSlot(victimSlot), .threshold(threshold),
    .slotValid(slotValid), .slotInEvict(slotInEvict)
  );

  // cost unit model: answers a held request one cycle after it is seen
  always @(negedge clk) begin
    if (rst || !respEn)      respValid <= 1'b0;
    else if (respValid)      respValid <= 1'b0;
    else if (costReq) begin
      respValid <= 1'b1;
      respVal   <= costTable[costSlot];
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    summary();
    $finish;
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; accValid = 1'b0; accHit = 1'b0; accSlot = '0; accPages = '0;
    accCost = '0; evictReq = 1'b0; dynMode = 1'b0; respEn = 1'b0;
    manValid = 1'b0; manVal = '0;
    for (int i = 0; i < N; i++) costTable[i] = CMAX;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic access(input int slot, input logic hit, input int pages, input logic [31:0] cost);
    accValid = 1'b1; accSlot = 4'(slot); accHit = hit; accPages = 7'(pages); accCost = cost;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic evictOne(output logic v, output logic [3:0] s);
    evictReq = 1'b1;
    @(negedge clk);
    evictReq = 1'b0;
    v = victimValid;
    s = victimSlot;
  endtask

  task automatic waitIdle();
    repeat (3) @(negedge clk);
    while (costReq) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    check("R1", "slotValid", 64'(slotValid), 64'h0);
    check("R1", "slotInEvict", 64'(slotInEvict), 64'h0);
    check("R1", "threshold", 64'(threshold), 64'(STEP));
    check("R1", "costReq", 64'(costReq), 64'h0);
    check("R1", "victimValid", 64'(victimValid), 64'h0);
  endtask

  task automatic testWorkOrder();
    logic v; logic [3:0] s;
    doReset(); respEn = 1'b1;
    access(0, 1'b0, 1, CMAX); waitIdle();
    access(1, 1'b0, 1, CMAX); waitIdle();
    access(2, 1'b0, 1, CMAX); waitIdle();
    check("R4", "slotValid after fills", 64'(slotValid), 64'h7);
    access(0, 1'b1, 2, CMAX); waitIdle();
    evictOne(v, s);
    check("R3", "victim after hit on 0", 64'({v, s}), 64'({1'b1, 4'd1}));
    evictOne(v, s);
    check("R4", "second victim", 64'({v, s}), 64'({1'b1, 4'd2}));
    evictOne(v, s);
    check("R4", "third victim", 64'({v, s}), 64'({1'b1, 4'd0}));
  endtask

  task automatic testScanOrder();
    logic v; logic [3:0] s;
    doReset();
    costTable[1] = 32'h0; costTable[2] = 32'h0;
    access(0, 1'b0, 1, CMAX);
    access(1, 1'b0, 1, CMAX);
    access(2, 1'b0, 1, CMAX);
    respEn = 1'b1; waitIdle();
    // R8 slot 0 (oldest) is too costly, slot 1 moves; R9 stops before slot 2
    check("R9", "eviction list after scan", 64'(slotInEvict), 64'h2);
    check("R11", "static threshold", 64'(threshold), 64'(STEP));
    evictOne(v, s);
    check("R2", "victim from eviction list", 64'({v, s}), 64'({1'b1, 4'd1}));
    check("R2", "victim freed", 64'(slotValid), 64'h5);
    evictOne(v, s);
    check("R3", "victim from work list", 64'({v, s}), 64'({1'b1, 4'd0}));
    evictOne(v, s);
    evictOne(v, s);
    check("R2", "no victim when empty", 64'(v), 64'h0);
  endtask

  task automatic testPreempt();
    doReset();
    costTable[0] = 32'h0;
    access(0, 1'b0, 1, CMAX);
    repeat (3) @(negedge clk);
    check("R7", "scan request after write", 64'(costReq), 64'h1);
    check("R8", "requested slot", 64'(costSlot), 64'h0);
    manValid = 1'b1; manVal = 32'h0;
    accValid = 1'b1; accSlot = 4'd5; accHit = 1'b0; accPages = 7'd1; accCost = CMAX;
    @(negedge clk);
    manValid = 1'b0; accValid = 1'b0;
    check("R10", "response dropped on write", 64'(slotInEvict), 64'h0);
    repeat (3) @(negedge clk);
    check("R10", "rescan from oldest", 64'({costReq, costSlot}), 64'({1'b1, 4'd0}));
    respEn = 1'b1; waitIdle();
    check("R8", "cheap block moved", 64'(slotInEvict), 64'h1);
  endtask

  task automatic testReeval();
    doReset(); respEn = 1'b1;
    costTable[0] = 32'h0;
    access(0, 1'b0, 1, CMAX); waitIdle();
    costTable[0] = CMAX;
    access(0, 1'b1, 2, 32'h0);
    check("R5", "cheap hit stays", 64'(slotInEvict), 64'h1);
    waitIdle();
    access(0, 1'b1, 3, STEP + 32'd1);
    check("R5", "costly hit returns", 64'(slotInEvict), 64'h0);
    waitIdle();
  endtask

  task automatic testPageFull();
    logic v; logic [3:0] s;
    doReset(); respEn = 1'b1;
    costTable[0] = 32'h0;
    access(0, 1'b0, 1, CMAX); waitIdle();
    access(1, 1'b0, 1, CMAX); waitIdle();
    access(1, 1'b1, 64, CMAX);
    check("R6", "full block in eviction list", 64'(slotInEvict), 64'h3);
    waitIdle();
    access(2, 1'b0, 1, CMAX);
    repeat (3) @(negedge clk);
    check("R7", "no scan above floor", 64'(costReq), 64'h0);
    evictOne(v, s);
    check("R6", "full block evicted first", 64'({v, s}), 64'({1'b1, 4'd1}));
    evictOne(v, s);
    check("R2", "next eviction-list victim", 64'({v, s}), 64'({1'b1, 4'd0}));
  endtask

  task automatic testDynamic();
    doReset(); respEn = 1'b1; dynMode = 1'b1;
    access(0, 1'b0, 1, CMAX); waitIdle();
    check("R11", "raise after empty scan", 64'(threshold), 64'(STEP * 2));
    costTable[1] = STEP * 2;
    access(1, 1'b0, 1, CMAX); waitIdle();
    check("R8", "cost equal to threshold moves", 64'(slotInEvict), 64'h2);
    check("R11", "lower after full scan", 64'(threshold), 64'(STEP));
    costTable[2] = 32'h0;
    access(2, 1'b0, 1, CMAX); waitIdle();
    check("R9", "second move", 64'(slotInEvict), 64'h6);
    check("R11", "floor clamp", 64'(threshold), 64'(STEP));
  endtask

  initial begin
    testReset();
    testWorkOrder();
    testScanOrder();
    testPreempt();
    testReeval();
    testPageFull();
    testDynamic();
    summary();
    $finish;
  end
endmodule